// File: doc/BRIEF.md
# Power-Bus Command Channel

This block is one command channel placed ahead of the master of a serial power-management bus. Software first loads up to two 32-bit data words and then writes one command word. The channel splits the command into its fields and presents a request to a downstream bus engine. The engine is modelled here as a request held until an acknowledge with a two-bit response code. The channel keeps the request steady until that acknowledge or until its own watchdog expires. It then captures any read data and posts a completion status that software polls.

The channel's registers sit in a 128-byte window at 0x800 + 0x80·CHAN of a 12-bit register address space. The same space holds two platform registers: a read-only version word at 0x000 and an interrupt-enable word at 0x004, whose bit 0 drives an output pin.

Every register write is a single-cycle strobe. Reads are combinational from the address.

Top module: `cmd_chan`

## Requirements
- R1: After reset, `eng_req` is 0; the status, read-data, config and interrupt-enable registers read 0; and address 0x000 returns the VERSION parameter.
- R2: Within the window, the config register at +0x04 (8 bits) and the data words at +0x10 (bytes 0-3) and +0x14 (bytes 4-7) read back what was written. The interrupt-enable register at 0x004 reads back bit 0 only, and that bit drives `irq_en`.
- R3: A command word written to +0x00 while idle has this layout: opcode in bits [31:27], slave ID in [23:20], address in [19:4] and byte count minus one in [2:0]. From the next cycle, `eng_req` is high with those fields on `eng_opc`, `eng_sid`, `eng_addr` and `eng_cnt`, held unchanged until the request ends.
- R4: `eng_wdata` carries byte k of the transfer in bits [8k+7:8k], little-endian: data word +0x10 supplies bytes 0-3 and data word +0x14 supplies bytes 4-7. Bytes above the count are driven 0.
- R5: A command whose opcode field has bit 4 set and low nibble 3, 4, 5 or 6 is a no-data command (reset, sleep, shutdown, wakeup). Its `eng_addr`, `eng_cnt` and `eng_wdata` are 0. Opcode field 16 (zero-write) is not a no-data command and keeps its address.
- R6: Starting a command clears the status register to 0. The status keeps its final value until the next accepted command.
- R7: The status register at +0x08 has DONE in bit 0, FAILURE in bit 1, DENIED in bit 2 and DROPPED in bit 3. An acknowledge with `eng_rsp` = 0 (ok), 1 (failed), 2 (denied) or 3 (dropped) posts 0x1, 0x3, 0x5 or 0x9 respectively, on the edge that samples the acknowledge.
- R8: A read command is one with opcode field 1, 8, 13 or 15. When it is acknowledged with `eng_rsp` = 0, `eng_rdata` is stored in +0x18 (bytes 0-3) and +0x1C (bytes 4-7) on the same edge that sets DONE, with bytes above the count stored as 0. Other completions leave the read-data registers unchanged.
- R9: A command write while `eng_req` is high is ignored: the request fields, the status and the eventual completion stay those of the command in flight.
- R10: If no acknowledge arrives within TIMEOUT cycles of `eng_req` being high, the channel drops `eng_req` on the TIMEOUT-th edge and posts status 0x3.
- R11: An acknowledge sampled on the same edge as the watchdog expiry takes priority, and its response code sets the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| irq_en | output | 1 | Interrupt-enable bit |
| eng_req | output | 1 | Request to the bus engine, held until acknowledge or timeout |
| eng_opc | output | 5 | Opcode field |
| eng_sid | output | 4 | Slave ID |
| eng_addr | output | 16 | Register address on the serial bus |
| eng_cnt | output | 3 | Byte count minus one |
| eng_wdata | output | 64 | Write bytes, byte 0 in bits [7:0] |
| eng_ack | input | 1 | Engine acknowledge, one cycle |
| eng_rsp | input | 2 | Response code sampled with `eng_ack` |
| eng_rdata | input | 64 | Read bytes sampled with `eng_ack` |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is the engine acknowledge and the watchdog expiry. The bench waits exactly TIMEOUT-1 edges after a command, then raises the acknowledge with an ok code so that it is sampled on the expiry edge, and requires status 0x1 rather than the timeout value 0x3. The second pair is a new command write and a request in flight. It is provoked by writing a second command while the first is still waiting. The scoreboard must then see no second request, the fields at the ports must stay those of the first command, and the final status must belong to the first command.

// File: rtl/cmd_chan.sv
module cmd_chan #(
  parameter int          CHAN    = 0,
  parameter int          TIMEOUT = 100,
  parameter logic [31:0] VERSION = 32'h0002_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_en,
  output logic        eng_req,
  output logic [4:0]  eng_opc,
  output logic [3:0]  eng_sid,
  output logic [15:0] eng_addr,
  output logic [2:0]  eng_cnt,
  output logic [63:0] eng_wdata,
  input  logic        eng_ack,
  input  logic [1:0]  eng_rsp,
  input  logic [63:0] eng_rdata
);

  localparam logic [11:0] BASE = 12'(32'h800 + CHAN * 32'h80);
  localparam int          WD_W = $clog2(TIMEOUT + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT - 1);

  localparam logic [6:0] O_CMD = 7'h00, O_CFG = 7'h04, O_STS = 7'h08,
                         O_WD0 = 7'h10, O_WD1 = 7'h14, O_RD0 = 7'h18, O_RD1 = 7'h1C;

  function automatic logic [63:0] byte_mask(input logic [2:0] cnt);
    logic [63:0] m;
    for (int i = 0; i < 8; i++) m[8*i +: 8] = (3'(i) <= cnt) ? 8'hFF : 8'h00;
    return m;
  endfunction

  logic [31:0]     wd0, wd1, rd0, rd1;
  logic [7:0]      cfg;
  logic [3:0]      status;
  logic            rd_op;
  logic [WD_W-1:0] wd_cnt;

  wire       in_win  = bus_addr[11:7] == BASE[11:7];
  wire [6:0] off     = bus_addr[6:0];
  wire       wr_win  = bus_wr && in_win;
  wire       hit_cmd = wr_win && off == O_CMD;
  wire       start   = hit_cmd && !eng_req;
  wire       expire  = eng_req && !eng_ack && wd_cnt == WD_LAST;

  wire [4:0] c_opc    = bus_wdata[31:27];
  wire       c_nodata = c_opc[4] && c_opc[3:0] >= 4'd3 && c_opc[3:0] <= 4'd6;
  wire       c_read   = c_opc == 5'd1 || c_opc == 5'd8 || c_opc == 5'd13 || c_opc == 5'd15;
  wire [2:0] c_cnt    = c_nodata ? 3'd0 : bus_wdata[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd0 <= '0; wd1 <= '0; cfg <= '0; irq_en <= 1'b0;
    end else begin
      if (wr_win && off == O_WD0) wd0 <= bus_wdata;
      if (wr_win && off == O_WD1) wd1 <= bus_wdata;
      if (wr_win && off == O_CFG) cfg <= bus_wdata[7:0];
      if (bus_wr && bus_addr == 12'h004) irq_en <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_req   <= 1'b0;
      eng_opc   <= '0;
      eng_sid   <= '0;
      eng_addr  <= '0;
      eng_cnt   <= '0;
      eng_wdata <= '0;
      rd_op     <= 1'b0;
      status    <= '0;
      wd_cnt    <= '0;
      rd0       <= '0;
      rd1       <= '0;
    end else if (start) begin
      eng_req   <= 1'b1;
      eng_opc   <= c_opc;
      eng_sid   <= bus_wdata[23:20];
      eng_addr  <= c_nodata ? 16'h0 : bus_wdata[19:4];
      eng_cnt   <= c_cnt;
      eng_wdata <= c_nodata ? 64'h0 : ({wd1, wd0} & byte_mask(c_cnt));
      rd_op     <= c_read;
      status    <= '0;
      wd_cnt    <= '0;
    end else if (eng_req) begin
      if (eng_ack) begin
        eng_req <= 1'b0;
        status  <= {eng_rsp == 2'd3, eng_rsp == 2'd2, eng_rsp == 2'd1, 1'b1};
        if (rd_op && eng_rsp == 2'd0)
          {rd1, rd0} <= eng_rdata & byte_mask(eng_cnt);
      end else if (expire) begin
        eng_req <= 1'b0;
        status  <= 4'b0011;
      end else begin
        wd_cnt <= wd_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 12'h000)      bus_rdata = VERSION;
    else if (bus_addr == 12'h004) bus_rdata = {31'b0, irq_en};
    else if (in_win) begin
      case (off)
        O_CFG:   bus_rdata = {24'b0, cfg};
        O_STS:   bus_rdata = {28'b0, status};
        O_WD0:   bus_rdata = wd0;
        O_WD1:   bus_rdata = wd1;
        O_RD0:   bus_rdata = rd0;
        O_RD1:   bus_rdata = rd1;
        default: bus_rdata = '0;
      endcase
    end
  end

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_ack && wd_cnt != WD_LAST |=> eng_req);
  a_r9_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> $stable(eng_opc) && $stable(eng_sid) && $stable(eng_addr) && $stable(eng_cnt) && $stable(eng_wdata));
  a_r6_status_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> status == 4'b0000);
  a_r7_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_ack |=> !eng_req && status[0] && $countones(status[3:1]) <= 1);
  a_r7_qual_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    status[3:1] != 3'b000 |-> status[0]);
  a_r10_wd_bound: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> wd_cnt <= WD_LAST);
  a_r5_nodata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_opc[4] && eng_opc[3:0] >= 4'd3 && eng_opc[3:0] <= 4'd6 |-> eng_addr == 16'h0 && eng_cnt == 3'd0);

endmodule

// File: tb/cmd_chan_tb.sv
`timescale 1ns/1ps
module cmd_chan_tb;
  localparam int T = 16;
  localparam logic [31:0] VER = 32'hA5_01_02_03;
  localparam logic [11:0] B = 12'h880;

  logic clk = 0, rst_n = 0, bus_wr = 0, eng_ack = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq_en, eng_req;
  logic [4:0] eng_opc; logic [3:0] eng_sid; logic [15:0] eng_addr; logic [2:0] eng_cnt;
  logic [63:0] eng_wdata, eng_rdata = 0;
  logic [1:0] eng_rsp = 0;
  int checks = 0, fails = 0;
  logic [91:0] expq[$];
  logic prev_req = 0;

  always #2.5 clk = ~clk;

  cmd_chan #(.CHAN(1), .TIMEOUT(T), .VERSION(VER)) u_dut (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .irq_en,
    .eng_req, .eng_opc, .eng_sid, .eng_addr, .eng_cnt, .eng_wdata,
    .eng_ack, .eng_rsp, .eng_rdata);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] keep(input logic [63:0] d, input int c);
    logic [127:0] m = (128'h1 << (8 * (c + 1))) - 1;
    return d & m[63:0];
  endfunction

  function automatic logic [31:0] cmdw(input logic [4:0] o, input logic [3:0] s,
                                       input logic [15:0] a, input logic [2:0] c);
    return {o, 3'b0, s, a, 1'b0, c};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic issue(input logic [4:0] o, input logic [3:0] s, input logic [15:0] a,
                       input logic [2:0] c, input logic [63:0] expw,
                       input logic [15:0] ea, input logic [2:0] ec);
    expq.push_back({o, s, ea, ec, expw});
    wr(B + 12'h00, cmdw(o, s, a, c));
  endtask

  task automatic respond(input logic [1:0] r, input logic [63:0] d);
    @(negedge clk); eng_ack = 1; eng_rsp = r; eng_rdata = d;
    @(negedge clk); eng_ack = 0;
  endtask

  // scoreboard monitor: each new request is compared with the oldest expectation
  always @(negedge clk) begin
    if (eng_req && !prev_req) begin
      logic [91:0] e;
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9: unexpected request actual %h expected none", {eng_opc, eng_sid, eng_addr, eng_cnt});
      end else begin
        e = expq.pop_front();
        chk("R3 request fields", {36'b0, eng_opc, eng_sid, eng_addr, eng_cnt}, {36'b0, e[91:64]});
        chk("R4 write bytes", eng_wdata, e[63:0]);
      end
    end
    prev_req <= eng_req;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk("R1 req", {63'b0, eng_req}, 0);
    rd(12'h000, v); chk("R1 version", v, VER);
    rd(12'h004, v); chk("R1 irq enable", v, 0);
    rd(B + 12'h08, v); chk("R1 status", v, 0);
    rd(B + 12'h18, v); chk("R1 rdata0", v, 0);
    rd(B + 12'h04, v); chk("R1 config", v, 0);
    // R2
    wr(B + 12'h04, 32'h1234_56A5); rd(B + 12'h04, v); chk("R2 config", v, 32'hA5);
    wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, v); chk("R2 irq enable", v, 1);
    chk("R2 irq pin", {63'b0, irq_en}, 1);
    wr(B + 12'h10, 32'h4433_2211); wr(B + 12'h14, 32'h8877_6655);
    rd(B + 12'h10, v); chk("R2 wdata0", v, 32'h4433_2211);
    rd(B + 12'h14, v); chk("R2 wdata1", v, 32'h8877_6655);
    // R3 R4 write of 6 bytes
    w = 64'h8877_6655_4433_2211;
    issue(5'd14, 4'd5, 16'h1234, 3'd5, keep(w, 5), 16'h1234, 3'd5);
    rd(B + 12'h08, v); chk("R6 status cleared while busy", v, 0);
    respond(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(B + 12'h08, v); chk("R7 ok status", v, 32'h1);
    rd(B + 12'h18, v); chk("R8 write op leaves rdata", v, 0);
    // R4 single byte and full
    issue(5'd2, 4'd1, 16'h0042, 3'd0, keep(w, 0), 16'h0042, 3'd0); respond(2'd1, 0);
    rd(B + 12'h08, v); chk("R7 failure status", v, 32'h3);
    issue(5'd0, 4'd15, 16'hBEEF, 3'd7, w, 16'hBEEF, 3'd7); respond(2'd2, 0);
    rd(B + 12'h08, v); chk("R7 denied status", v, 32'h5);
    rd(B + 12'h08, v); chk("R6 status held", v, 32'h5);
    issue(5'd9, 4'd2, 16'h0001, 3'd3, keep(w, 3), 16'h0001, 3'd3); respond(2'd3, 0);
    rd(B + 12'h08, v); chk("R7 dropped status", v, 32'h9);
    // R8 reads
    issue(5'd15, 4'd4, 16'h2000, 3'd2, keep(w, 2), 16'h2000, 3'd2);
    respond(2'd0, 64'hDEAD_BEEF_CAFE_F00D);
    rd(B + 12'h08, v); chk("R8 done with data", v, 32'h1);
    rd(B + 12'h18, v); chk("R8 rdata0 3 bytes", v, 32'h00FE_F00D);
    rd(B + 12'h1C, v); chk("R8 rdata1 3 bytes", v, 0);
    issue(5'd1, 4'd4, 16'h2001, 3'd7, w, 16'h2001, 3'd7);
    respond(2'd0, 64'h0102_0304_0506_0708);
    rd(B + 12'h18, v); chk("R8 rdata0 full", v, 32'h0506_0708);
    rd(B + 12'h1C, v); chk("R8 rdata1 full", v, 32'h0102_0304);
    issue(5'd8, 4'd4, 16'h2002, 3'd7, w, 16'h2002, 3'd7);
    respond(2'd1, 64'h5555_5555_5555_5555);
    rd(B + 12'h18, v); chk("R8 failed read leaves rdata", v, 32'h0506_0708);
    // R5
    issue(5'h14, 4'd3, 16'hFFFF, 3'd7, 64'h0, 16'h0, 3'd0); respond(2'd0, 0);
    issue(5'h10, 4'd3, 16'hABCD, 3'd1, keep(w, 1), 16'hABCD, 3'd1); respond(2'd0, 0);
    // R9
    issue(5'd14, 4'd6, 16'h7777, 3'd1, keep(w, 1), 16'h7777, 3'd1);
    wr(B + 12'h00, cmdw(5'd15, 4'd9, 16'h1111, 3'd4));
    chk("R9 addr kept", {48'b0, eng_addr}, 64'h7777);
    chk("R9 sid kept", {60'b0, eng_sid}, 6);
    rd(B + 12'h08, v); chk("R9 status untouched", v, 0);
    respond(2'd2, 0);
    rd(B + 12'h08, v); chk("R9 first command completes", v, 32'h5);
    // R10
    issue(5'd14, 4'd1, 16'h0010, 3'd0, keep(w, 0), 16'h0010, 3'd0);
    bus_addr = B + 12'h08;
    repeat (T - 1) @(posedge clk);
    #1 chk("R10 busy before limit", {32'b0, bus_rdata}, 0);
    chk("R10 req before limit", {63'b0, eng_req}, 1);
    @(posedge clk); #1
    chk("R10 timeout status", {32'b0, bus_rdata}, 32'h3);
    chk("R10 req dropped", {63'b0, eng_req}, 0);
    // R11
    issue(5'd14, 4'd1, 16'h0020, 3'd0, keep(w, 0), 16'h0020, 3'd0);
    bus_addr = B + 12'h08;
    repeat (T - 1) @(posedge clk);
    #1 eng_ack = 1; eng_rsp = 2'd0;
    @(posedge clk); #1 eng_ack = 0;
    chk("R11 ack beats expiry", {32'b0, bus_rdata}, 32'h1);
    repeat (2) @(negedge clk);
    chk("R3 all requests seen", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule